// File: doc/BRIEF.md
# Self-Recovering Modified One-Hot Sequencer

This block is a ring sequencer with N states held in only N-1 flip-flops. The state in which every flip-flop is clear is a legal state, called home. Each other state is marked by exactly one set bit, which is the token. Bit 0 is the first stage, and the token moves one place toward the top bit on every clock.

The first stage is not fed from the last stage. Its input is the NOR of the whole register. As a result, a register that has been cleared by an upset starts the ring again from home. Surplus tokens fall off the top end until at most one is left. No other error-handling logic is needed for this recovery.

With its default setting of four states, the block is a two-phase clock generator whose phases never overlap. One phase is high in one state and the other phase is high in a different state. A fault mask input flips chosen bits of the value loaded at an edge, so that upsets can be injected. A flag reports when more than one token is present. All outputs are registered.

Top module: `mohot_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the state register, both phase outputs and the multi-token flag are cleared on that edge, whatever `fault_mask` holds.
- R2: With `fault_mask` zero, starting from home (all bits 0), the register steps through the codes 001, 010, 100 and back to 000 (default N=4). This gives a period of N cycles, and state k is the code with only bit k-1 set.
- R3: With `fault_mask` zero, each bit i>0 takes the previous value of bit i-1 at each edge. The top bit is discarded.
- R4: Every bit set in `fault_mask` at a rising edge outside reset inverts the matching bit of the value loaded at that edge.
- R5: With `fault_mask` zero, a register holding several set bits reaches a pattern with at most one set bit within N-1 cycles. The number of set bits never grows while more than one is present.
- R6: If an upset leaves all bits at 0, the next edge with `fault_mask` zero loads 001, and normal sequencing resumes.
- R7: `phase1_o` is high exactly when the state is 001 (state One).
- R8: `phase2_o` is high exactly when the state is 100 (state Three).
- R9: `phase1_o` and `phase2_o` are never high in the same cycle.
- R10: `multi_tok_o` is high exactly when more than one state bit is set.
- R11: Outside injected faults, at most one state bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to home |
| fault_mask | input | N-1 | Bits to invert in the value loaded at this edge |
| state_o | output | N-1 | Registered state bits, bit 0 is the first stage |
| phase1_o | output | 1 | First clock phase, high in state One |
| phase2_o | output | 1 | Second clock phase, high in state Three |
| multi_tok_o | output | 1 | More than one state bit set |

## Verification
The states that matter most are the illegal ones: a register cleared outside home, and a register holding two or three tokens. Neither state can be reached through normal sequencing. The bench reaches them by driving `fault_mask` for a single edge at chosen points in the ring. For example, it flips the bit that is about to receive the token, which leaves the register empty. It also flips an upper bit while a token is present, or several bits together. After each injection it releases the mask, follows the shift-out or the restart cycle by cycle against a behavioural model, and checks that the phase outputs stay disjoint throughout.

// File: rtl/mohot_pkg.sv
package mohot_pkg;
  localparam int unsigned MAX_RING = 32;

  // code of state idx: home (0) is all zero, state k has bit k-1 set
  function automatic logic [MAX_RING-1:0] state_code(input int unsigned idx);
    logic [MAX_RING-1:0] c;
    c = '0;
    if (idx > 0) c[idx-1] = 1'b1;
    return c;
  endfunction

  function automatic int unsigned pop_count(input logic [MAX_RING-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MAX_RING; i++) n += v[i];
    return n;
  endfunction
endpackage

// File: rtl/mohot_ring.sv
module mohot_ring #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] fault_mask,
  output logic [W-1:0] state_d,
  output logic [W-1:0] state_q
);
  logic         at_home;
  logic [W-1:0] shifted;

  always_comb begin
    at_home = ~|state_q;
    shifted = {state_q[W-2:0], at_home};
    state_d = rst ? '0 : (shifted ^ fault_mask);
  end

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end

  // R3
  shift_path_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_mask == '0) |=> (state_q[W-1:1] == $past(state_q[W-2:0])));

  // R6
  home_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_mask == '0 && state_q == '0) |=> (state_q == {{(W-1){1'b0}}, 1'b1}));

  // R5
  token_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_mask == '0 && $countones(state_q) > 1)
      |=> ($countones(state_q) <= $countones($past(state_q))));
endmodule

// File: rtl/mohot_phase_dec.sv
module mohot_phase_dec
  import mohot_pkg::*;
#(
  parameter int unsigned W         = 3,
  parameter int unsigned STATE_IDX = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] state_d,
  input  logic [W-1:0] state_q,
  output logic         phase_q
);
  localparam logic [MAX_RING-1:0] CODE_FULL = state_code(STATE_IDX);
  localparam logic [W-1:0]        CODE      = CODE_FULL[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) phase_q <= 1'b0;
    else     phase_q <= (state_d == CODE);
  end

  // R7 R8
  phase_match_chk: assert property (@(posedge clk) disable iff (rst)
    phase_q == (state_q == CODE));
endmodule

// File: rtl/mohot_token_mon.sv
module mohot_token_mon
  import mohot_pkg::*;
#(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] state_d,
  input  logic [W-1:0] state_q,
  output logic         multi_q
);
  logic [MAX_RING-1:0] wide_d;
  logic                many_d;

  always_comb begin
    wide_d        = '0;
    wide_d[W-1:0] = state_d;
    many_d        = (pop_count(wide_d) > 1);
  end

  always_ff @(posedge clk) begin
    if (rst) multi_q <= 1'b0;
    else     multi_q <= many_d;
  end

  // R10
  multi_flag_chk: assert property (@(posedge clk) disable iff (rst)
    multi_q == ($countones(state_q) > 1));
endmodule

// File: rtl/mohot_sequencer.sv
module mohot_sequencer #(
  parameter int unsigned N_STATES  = 4,
  parameter int unsigned PH1_STATE = 1,
  parameter int unsigned PH2_STATE = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_STATES-2:0] fault_mask,
  output logic [N_STATES-2:0] state_o,
  output logic                phase1_o,
  output logic                phase2_o,
  output logic                multi_tok_o
);
  localparam int unsigned W        = N_STATES - 1;
  localparam int unsigned N_PHASES = 2;
  localparam int unsigned PH_IDX [N_PHASES] = '{PH1_STATE, PH2_STATE};

  logic [W-1:0]        state_d;
  logic [W-1:0]        state_q;
  logic [N_PHASES-1:0] phase_q;

  mohot_ring #(.W(W)) u_ring (
    .clk        (clk),
    .rst        (rst),
    .fault_mask (fault_mask),
    .state_d    (state_d),
    .state_q    (state_q)
  );

  for (genvar g = 0; g < N_PHASES; g++) begin : g_phase
    mohot_phase_dec #(.W(W), .STATE_IDX(PH_IDX[g])) u_dec (
      .clk     (clk),
      .rst     (rst),
      .state_d (state_d),
      .state_q (state_q),
      .phase_q (phase_q[g])
    );
  end

  mohot_token_mon #(.W(W)) u_mon (
    .clk     (clk),
    .rst     (rst),
    .state_d (state_d),
    .state_q (state_q),
    .multi_q (multi_tok_o)
  );

  assign state_o  = state_q;
  assign phase1_o = phase_q[0];
  assign phase2_o = phase_q[1];

  // R9
  phase_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
    !(phase1_o && phase2_o));

  // R2
  ring_start_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_mask == '0 && state_o == {{(W-1){1'b0}}, 1'b1})
      |=> (state_o == {{(W-2){1'b0}}, 2'b10}));
endmodule

// File: tb/test_mohot_sequencer.sv
`timescale 1ns/1ps
module test_mohot_sequencer;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] fault_mask = '0;
  logic [W-1:0] state_o;
  logic         phase1_o, phase2_o, multi_tok_o;

  int n_checks = 0;
  int n_fail   = 0;
  int mdl      = 0;   // reference state as an integer

  always #4 clk = ~clk;

  mohot_sequencer i_mohot_sequencer (
    .clk(clk), .rst(rst), .fault_mask(fault_mask),
    .state_o(state_o), .phase1_o(phase1_o), .phase2_o(phase2_o),
    .multi_tok_o(multi_tok_o)
  );

  function automatic int ones(input int v);
    int c = 0;
    for (int i = 0; i < W; i++) if ((v >> i) & 1) c++;
    return c;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(input int mask, input string tag);
    fault_mask = mask[W-1:0];
    @(posedge clk);
    if (rst) mdl = 0;
    else begin
      int nxt;
      nxt = ((mdl * 2) % (1 << W)) + ((mdl == 0) ? 1 : 0);
      mdl = nxt ^ mask;
    end
    @(negedge clk);
    chk({tag, " state"}, int'(state_o), mdl);
    chk("R7 phase1", int'(phase1_o), (mdl == 1) ? 1 : 0);
    chk("R8 phase2", int'(phase2_o), (mdl == 4) ? 1 : 0);
    chk("R9 overlap", int'(phase1_o && phase2_o), 0);
    chk("R10 multi", int'(multi_tok_o), (ones(mdl) > 1) ? 1 : 0);
  endtask

  initial begin
    @(negedge clk);
    // R1: reset with a full fault mask still clears everything
    for (int i = 0; i < 3; i++) step(7, "R1");
    rst = 1'b0;
    // R2/R3: two full laps from home
    for (int i = 0; i < 8; i++) step(0, "R2/R3");
    step(0, "R2");                         // 001
    // R4: flip top bit while token moves to 010 -> 110
    step(4, "R4");
    for (int i = 0; i < 2; i++) step(0, "R5");
    chk("R5 drained", (ones(int'(state_o)) <= 1) ? 1 : 0, 1);
    step(0, "R5");                         // home -> 001
    // R6: clear the token as it moves: 010^010 = 000
    step(2, "R6");
    chk("R6 empty", int'(state_o), 0);
    step(0, "R6");
    chk("R6 restart", int'(state_o), 1);
    // R4: three tokens 010^101 = 111, then drain
    step(5, "R4");
    for (int i = 0; i < W; i++) step(0, "R5");
    chk("R5 drained", (ones(int'(state_o)) <= 1) ? 1 : 0, 1);
    // R4: hold home by cancelling the restart bit
    while (mdl != 0) step(0, "R2");
    step(1, "R4");
    step(0, "R6");
    // R1: reset mid-run
    step(0, "R2");
    rst = 1'b1;
    step(3, "R1");
    rst = 1'b0;
    // R11: long undisturbed run keeps at most one token
    for (int i = 0; i < 20; i++) begin
      step(0, "R11");
      chk("R11 onehot0", (ones(int'(state_o)) <= 1) ? 1 : 0, 1);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule